// File: doc/BRIEF.md
# Flash Bulk-Erase Command Decoder

This block models the command side of a byte-wide parallel NOR flash for the bulk-erase flow. The strobes are sampled on a system clock. It watches active-low chip-enable and write-enable. An address is captured when the second of the two strobes goes low. The command byte is acted on when the write ends. Only two command codes matter here: 20h, the erase code, and A0h, the erase-verify code. Every other byte counts as some other valid command.

An erase begins only after the erase code has been written twice in a row while the high-voltage flag is set. Once begun, the erase does not stop on its own. It runs until the next command write. Writing A0h ends the erase and enters erase-verify, and each A0h write picks the byte whose erase state is read back.

The cell array is abstract: a map of erased bits, with 2**MAP_AW bytes indexed by the low address bits. While the erase is active, the erase advances one bit every TICKS clock cycles, in a fixed sweep order. An erase that is cut short therefore leaves a known prefix of bits erased. A new erase restarts the sweep from the first bit, and bits that are already erased stay erased.

Top module: `fcmd_erase_ctrl`

## Requirements
- R1: After reset, erase_active is 0 and every byte of the array reads 00h (no bit erased).
- R2: Writing 20h from idle enters erase-setup. It does not raise erase_active and does not change any array byte.
- R3: A second 20h write in erase-setup, with hv_present high, raises erase_active on the clock edge where the write strobe ends. From idle, a single 20h never starts an erase.
- R4: erase_active stays high until the next command write ends. A0h ends the erase and enters erase-verify, and any other byte ends the erase and returns to idle.
- R5: The write address is captured when the later of ce_n and we_n goes low. Address changes after that point, or before the second strobe falls, have no effect.
- R6: In erase-verify, a read returns the latched byte as erased bits (1 = erased), so it reads FFh only when all 8 bits are erased. Bit k of byte b is erased by sweep step 8*b+k, and one step occurs per TICKS clock edges of active erase with hv_present high.
- R7: With hv_present low, the second 20h starts no erase and returns the decoder to idle. While hv_present is low, the array never changes, even during an active erase.
- R8: Each A0h write in erase-verify latches its own address. Verify reads return that latched byte whatever the current bus address is.
- R9: In erase-verify, 20h returns to erase-setup, and any byte other than 20h or A0h returns to idle. After either, reads follow the live bus address.
- R10: In erase-setup, any byte other than 20h returns to idle without erasing.
- R11: Every new erase restarts the sweep at bit 0, and erased bits are never cleared. The erased region is therefore the longest sweep reached by any erase since reset.
- R12: dout_en is 1 only while ce_n=0, oe_n=0 and we_n=1. Otherwise dout is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Command byte written by the host |
| hv_present | input | 1 | High programming voltage is present |
| dout | output | 8 | Read data (erased-bit view of the addressed byte) |
| dout_en | output | 1 | Read data is being driven |
| erase_active | output | 1 | Bulk erase is in progress |

## Verification
The assertions check on every cycle that an erase starts only from erase-setup, on a 20h write with high voltage present. They also check that it holds until a write ends and stops on that write. The array may change only during an active, powered erase, and erased bits never clear. A new write start must capture the address present at that moment, and other commands must leave erase-verify. What only the scenarios can show is the read-back content: partial erases of chosen lengths, repeat erases that are shorter and longer, an interruption by a voltage drop, and verification byte by byte across the whole array. All of these are compared with a count of erased bits computed in the bench.

// File: rtl/fcmd_pkg.sv
// Shared types for the flash erase command decoder.
// Assumes one byte-wide command bus; the codes below are the only ones decoded.
package fcmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ERASE  = 2'd2,
        ST_VERIFY = 2'd3
    } fcmd_state_e;

    localparam logic [7:0] CODE_ERASE  = 8'h20;
    localparam logic [7:0] CODE_VERIFY = 8'hA0;

endpackage

// File: rtl/fcmd_bus_capture.sv
// Samples the asynchronous write strobes on clk and forms write start/end
// pulses. The address is captured when the combined strobe (both low) begins,
// i.e. on the later falling strobe; the data byte is tracked while it lasts.
// Assumes ce_n/we_n/addr/din are already synchronous to clk.
module fcmd_bus_capture #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_start,
    output logic              wr_end,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data
);

    logic strobe;
    logic strobe_q;

    assign strobe   = !ce_n && !we_n;
    assign wr_start = strobe && !strobe_q;
    assign wr_end   = !strobe && strobe_q;

    // Remember the strobe level of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Capture the address once per write, when the second strobe falls.
    always_ff @(posedge clk) begin
        if (!rst_n)        lat_addr <= '0;
        else if (wr_start) lat_addr <= addr;
    end

    // Follow the data bus while the write is open; the last value is the command.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_data <= '0;
        else if (strobe) lat_data <= din;
    end

endmodule

// File: rtl/fcmd_seq.sv
// Command sequencer: idle -> setup -> erasing -> verify. Acts only when a
// write ends. Erase needs two consecutive erase codes with high voltage present.
// Assumes cmd is stable in the cycle wr_end is high.
module fcmd_seq
    import fcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_end,
    input  logic [7:0]  cmd,
    input  logic        hv_present,
    output fcmd_state_e state,
    output logic        erase_start,
    output logic        verify_load
);

    fcmd_state_e state_nx;
    logic        is_erase_code;
    logic        is_verify_code;

    assign is_erase_code  = (cmd == CODE_ERASE);
    assign is_verify_code = (cmd == CODE_VERIFY);

    assign erase_start = wr_end && (state == ST_SETUP) && is_erase_code && hv_present;
    assign verify_load = wr_end && is_verify_code &&
                         ((state == ST_ERASE) || (state == ST_VERIFY));

    // Next-state decode for a completed command write.
    always_comb begin
        state_nx = state;
        if (wr_end) begin
            unique case (state)
                ST_IDLE:   state_nx = is_erase_code ? ST_SETUP : ST_IDLE;
                ST_SETUP:  state_nx = erase_start ? ST_ERASE : ST_IDLE;
                ST_ERASE:  state_nx = is_verify_code ? ST_VERIFY : ST_IDLE;
                ST_VERIFY: begin
                    if (is_verify_code)     state_nx = ST_VERIFY;
                    else if (is_erase_code) state_nx = ST_SETUP;
                    else                    state_nx = ST_IDLE;
                end
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

endmodule

// File: rtl/fcmd_cell_model.sv
// Abstract cell array: one erased flag per bit of 2**MAP_AW bytes. An active
// erase sweeps bit 8*b+k in ascending order, one bit every TICKS enabled cycles,
// restarting at bit 0 on each new erase. Flags are only ever set.
module fcmd_cell_model #(
    parameter int MAP_AW = 4,
    parameter int TICKS  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        erase_start,
    input  logic                        step_en,
    input  logic [MAP_AW-1:0]           rd_idx,
    output logic [7:0]                  rd_byte,
    output logic [(2**MAP_AW)*8-1:0]    erased_flat
);

    localparam int DEPTH = 2 ** MAP_AW;
    localparam int NBITS = DEPTH * 8;
    localparam int IDX_W = $clog2(NBITS);
    localparam int PTR_W = IDX_W + 1;
    localparam int PRE_W = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PRE_W-1:0] pre_q;
    logic [NBITS-1:0] erased_q;
    logic             step_due;
    logic             sweep_done;
    logic [7:0]       byte_view [DEPTH];

    assign sweep_done = (ptr_q == PTR_W'(NBITS));
    assign step_due   = step_en && (pre_q == PRE_W'(TICKS - 1));

    // Prescaler and sweep pointer; both restart when a new erase begins.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_start) begin
            ptr_q <= '0;
            pre_q <= '0;
        end else if (step_en) begin
            if (step_due) begin
                pre_q <= '0;
                if (!sweep_done) ptr_q <= ptr_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // Set the erased flag of the bit under the sweep pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)                       erased_q <= '0;
        else if (step_due && !sweep_done) erased_q[ptr_q[IDX_W-1:0]] <= 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        assign byte_view[g] = erased_q[g*8 +: 8];
    end

    assign rd_byte     = byte_view[rd_idx];
    assign erased_flat = erased_q;

endmodule

// File: rtl/fcmd_erase_ctrl.sv
// Top of the erase command decoder: strobe capture, command sequencer,
// verify address register and the abstract array. Reads return the erased-bit
// view of the verify byte in erase-verify, otherwise of the bus address.
// Assumes all bus inputs are synchronous to clk.
module fcmd_erase_ctrl
    import fcmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int MAP_AW = 4,
    parameter int TICKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              hv_present,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              erase_active
);

    localparam int NBITS = (2 ** MAP_AW) * 8;

    logic              cap_wr_start;
    logic              cap_wr_end;
    logic [ADDR_W-1:0] cap_addr;
    logic [7:0]        cap_cmd;
    fcmd_state_e       st_q;
    logic              seq_erase_start;
    logic              seq_verify_load;
    logic [ADDR_W-1:0] vaddr_q;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        cell_byte;
    logic [NBITS-1:0]  erased_flat;

    fcmd_bus_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .addr     (addr),
        .din      (din),
        .wr_start (cap_wr_start),
        .wr_end   (cap_wr_end),
        .lat_addr (cap_addr),
        .lat_data (cap_cmd)
    );

    fcmd_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_end      (cap_wr_end),
        .cmd         (cap_cmd),
        .hv_present  (hv_present),
        .state       (st_q),
        .erase_start (seq_erase_start),
        .verify_load (seq_verify_load)
    );

    // Keep the address of the most recent accepted verify command.
    always_ff @(posedge clk) begin
        if (!rst_n)               vaddr_q <= '0;
        else if (seq_verify_load) vaddr_q <= cap_addr;
    end

    assign rd_addr = (st_q == ST_VERIFY) ? vaddr_q : addr;

    fcmd_cell_model #(
        .MAP_AW (MAP_AW),
        .TICKS  (TICKS)
    ) u_cells (
        .clk         (clk),
        .rst_n       (rst_n),
        .erase_start (seq_erase_start),
        .step_en     ((st_q == ST_ERASE) && hv_present),
        .rd_idx      (rd_addr[MAP_AW-1:0]),
        .rd_byte     (cell_byte),
        .erased_flat (erased_flat)
    );

    assign dout_en      = !ce_n && !oe_n && we_n;
    assign dout         = dout_en ? cell_byte : 8'h00;
    assign erase_active = (st_q == ST_ERASE);

    logic unused_start;
    assign unused_start = cap_wr_start;

endmodule

// File: rtl/fcmd_erase_chk.sv
// Property checker for fcmd_erase_ctrl, attached by bind below.
// Observes ports and the internal capture/sequencer/array signals.
module fcmd_erase_chk
    import fcmd_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int NBITS  = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              hv_present,
    input logic              erase_active,
    input logic              wr_end,
    input logic [7:0]        cmd,
    input fcmd_state_e       state,
    input logic [ADDR_W-1:0] lat_addr,
    input logic [NBITS-1:0]  erased_flat
);

    // Erase begins only from setup, on an erase-code write, with voltage present.
    assert_erase_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_active) |-> ($past(wr_end) && ($past(cmd) == CODE_ERASE) &&
                                 $past(hv_present) && ($past(state) == ST_SETUP)));

    // Erase persists while no write completes.
    assert_erase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_active && !wr_end) |=> erase_active);

    // Any completed write terminates the erase.
    assert_erase_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_active && wr_end) |=> !erase_active);

    // The address is taken when both strobes have just become low.
    assert_addr_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(!ce_n && !we_n) |=> (lat_addr == $past(addr)));

    // The array changes only during a powered, active erase.
    assert_array_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(erased_flat) |-> ($past(hv_present) && $past(erase_active)));

    // Erased flags are never cleared.
    assert_erase_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(erased_flat) & ~erased_flat) == '0));

    // Other commands leave erase-verify for idle.
    assert_verify_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_VERIFY) && wr_end && (cmd != CODE_VERIFY) && (cmd != CODE_ERASE))
        |=> (state == ST_IDLE));

endmodule

bind fcmd_erase_ctrl fcmd_erase_chk #(
    .ADDR_W (ADDR_W),
    .NBITS  (NBITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .we_n         (we_n),
    .addr         (addr),
    .hv_present   (hv_present),
    .erase_active (erase_active),
    .wr_end       (cap_wr_end),
    .cmd          (cap_cmd),
    .state        (st_q),
    .lat_addr     (cap_addr),
    .erased_flat  (erased_flat)
);

// File: tb/fcmd_erase_ctrl_tb.sv
// Self-checking bench: full-array verify sweeps after erases of computed length.
module fcmd_erase_ctrl_tb;

    localparam int ADDR_W = 17;
    localparam int MAP_AW = 4;
    localparam int TICKS  = 2;
    localparam int DEPTH  = 2 ** MAP_AW;
    localparam int NBITS  = DEPTH * 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1;
    logic              we_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = 8'h00;
    logic              hv_present = 1'b1;
    logic [7:0]        dout;
    logic              dout_en;
    logic              erase_active;

    int n_chk = 0;
    int n_bad = 0;
    int act_cnt = 0;
    int erased_total = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fcmd_erase_ctrl #(
        .ADDR_W (ADDR_W),
        .MAP_AW (MAP_AW),
        .TICKS  (TICKS)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_n         (ce_n),
        .we_n         (we_n),
        .oe_n         (oe_n),
        .addr         (addr),
        .din          (din),
        .hv_present   (hv_present),
        .dout         (dout),
        .dout_en      (dout_en),
        .erase_active (erase_active)
    );

    // Count powered active-erase cycles, the basis of the expected sweep length.
    always @(negedge clk) if (erase_active && hv_present) act_cnt++;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int idx);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[k] = ((idx * 8 + k) < erased_total);
        return b;
    endfunction

    // One command write; a_first is on the bus when the first strobe falls,
    // a_second when the later one falls.
    task automatic cmd_write(input logic [ADDR_W-1:0] a_first, input logic [ADDR_W-1:0] a_second,
                             input logic [7:0] d, input bit we_first);
        @(posedge clk); #1; addr = a_first; din = d;
        if (we_first) we_n = 1'b0; else ce_n = 1'b0;
        @(posedge clk); #1; addr = a_second;
        @(posedge clk); #1;
        if (we_first) ce_n = 1'b0; else we_n = 1'b0;
        @(posedge clk); #1; addr = a_second ^ 17'h1555F;
        @(posedge clk); #1; we_n = 1'b1;
        @(posedge clk); #1; ce_n = 1'b1; din = 8'h00;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        cmd_write(a, a, d, 1'b1);
    endtask

    task automatic read_chk(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
        @(posedge clk); #1; addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        check(dout_en === 1'b1, req, dout_en, 1);
        check(dout === exp, req, dout, exp);
        @(posedge clk); #1; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic ea_chk(input logic exp, input string req);
        @(negedge clk);
        check(erase_active === exp, req, erase_active, exp);
    endtask

    // Full erase flow: setup, start, hold, then A0h; hv dropped for gap cycles.
    task automatic run_erase(input int hold, input int gap);
        int run;
        wr(17'h00000, 8'h20);
        ea_chk(1'b0, "R2 setup alone");
        act_cnt = 0;
        wr(17'h00000, 8'h20);
        ea_chk(1'b1, "R3 erase started");
        repeat (hold) @(posedge clk);
        if (gap > 0) begin
            #1; hv_present = 1'b0;
            repeat (gap) @(posedge clk);
            #1; hv_present = 1'b1;
        end
        ea_chk(1'b1, "R4 erase still active");
        wr(17'h00000, 8'hA0);
        ea_chk(1'b0, "R4 erase ended by A0h");
        run = act_cnt / TICKS;
        if (run > NBITS) run = NBITS;
        if (run > erased_total) erased_total = run;
    endtask

    // Verify every byte with its own A0h; read at a different bus address.
    task automatic verify_all(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            wr({4'(i + 3), 9'h0, 4'(i)}, 8'hA0);
            read_chk({4'h0, 9'h0, 4'(i ^ 5)}, exp_byte(i), req);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1; rst_n = 1'b1;

        // R1: reset state
        ea_chk(1'b0, "R1 erase_active");
        for (int i = 0; i < DEPTH; i++) read_chk(17'(i), 8'h00, "R1 reset array");

        // R12: output enable conditions
        @(posedge clk); #1; ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); check(dout_en === 1'b0 && dout === 8'h00, "R12 oe high", dout_en, 0);
        @(posedge clk); #1; oe_n = 1'b0; we_n = 1'b0;
        @(negedge clk); check(dout_en === 1'b0 && dout === 8'h00, "R12 we low", dout_en, 0);
        @(posedge clk); #1; we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(posedge clk);

        // R2: one erase code changes nothing
        wr(17'h00002, 8'h20);
        ea_chk(1'b0, "R2 single code");
        read_chk(17'h00002, 8'h00, "R2 array unchanged");
        // R10: stray byte in setup aborts; next 20h only re-enters setup
        wr(17'h0, 8'h55);
        wr(17'h0, 8'h20);
        ea_chk(1'b0, "R10 stray byte aborted setup");
        wr(17'h0, 8'h00);

        // R7: no voltage, no erase; decoder falls back to idle
        #1; hv_present = 1'b0;
        wr(17'h0, 8'h20);
        wr(17'h0, 8'h20);
        ea_chk(1'b0, "R7 no erase without hv");
        #1; hv_present = 1'b1;
        wr(17'h0, 8'h20);
        ea_chk(1'b0, "R7 returned to idle");
        read_chk(17'h0, 8'h00, "R7 array unchanged");
        wr(17'h0, 8'h00);

        // Partial erase, then R5 address capture in both strobe orders
        run_erase(14, 0);
        cmd_write(17'h00000, 17'h00001, 8'hA0, 1'b1);
        read_chk(17'h0000F, exp_byte(1), "R5 we first, later ce");
        cmd_write(17'h00001, 17'h00000, 8'hA0, 1'b0);
        read_chk(17'h0000F, exp_byte(0), "R5 ce first, later we");
        verify_all("R6 partial sweep");

        // R9: other command leaves verify; reads follow the bus address
        wr(17'h0, 8'hFF);
        read_chk(17'h00000, exp_byte(0), "R9 live address byte0");
        read_chk(17'h00002, exp_byte(2), "R9 live address byte2");

        // R11: shorter re-erase keeps earlier bits
        run_erase(2, 0);
        verify_all("R11 short re-erase");

        // R7: voltage drop pauses the sweep (entered from verify, R9 20h path)
        run_erase(60, 40);
        verify_all("R7 hv gap sweep");

        // R8: two verify addresses read back differently
        wr(17'h10002, 8'hA0);
        read_chk(17'h00000, exp_byte(2), "R8 first verify addr");
        wr(17'h0000C, 8'hA0);
        read_chk(17'h00002, exp_byte(12), "R8 second verify addr");

        // R6: full erase, all bytes FFh
        run_erase(300, 0);
        check(erased_total == NBITS, "R6 full sweep length", erased_total, NBITS);
        verify_all("R6 full erase");

        wr(17'h0, 8'h00);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule